// File: doc/BRIEF.md
# Key-Unlocked Watchdog Timer

The block is a small watchdog for a microcontroller subsystem. It has an 8-bit counter that advances by one on every cycle where a dedicated watchdog tick enable is high, but only while the watchdog is running. If the counter wraps past its all-ones value while running, the block raises a reset request for one clock cycle. It also sets an expiry flag that stays set until software clears it.

Software reaches the block through a simple register port with a shared address, a write strobe, write data and combinational read data. The control register holds the run bit, the refresh action and the expiry flag. The block guards every control write with a two-byte unlock sequence on a separate key register: first 1Eh, then E1h. One control write uses up the unlock. A control write made without a complete unlock changes nothing.

After reset the watchdog is stopped, so software must unlock and set the run bit before any timeout can occur. A refresh goes through the same guarded path.

Top module: `kwdt_top`

Register map (2-bit address): 0 = control, 1 = key, 2 = counter (read-only), 3 = reads zero. Control fields: bit 0 = run (read/write), bit 1 = refresh (write 1 to clear the counter, reads 0), bit 7 = expiry flag (write 1 to clear). All other control bits read zero. A read of the key register returns the unlock state: 0 = idle, 1 = first byte seen, 2 = unlocked.

## Requirements
- R1: After a synchronous reset, every register address reads zero and `wdt_reset_req` is low.
- R2: Writing 1Eh and then E1h to the key register unlocks the control register. The next control write then takes effect in the following cycle.
- R3: A key write that is not the byte expected next returns the unlock state to idle (0). In the first-byte state, any value other than E1h goes to idle. In the idle or unlocked state, 1Eh moves to state 1 and any other value goes to idle.
- R4: A control write made while the unlock state is not 2 leaves the run bit, the expiry flag, the counter and the unlock state unchanged.
- R5: A control write made in the unlocked state uses up the unlock. The state returns to 0, and a second control write is ignored until the key sequence is repeated.
- R6: While the run bit is 1, the counter increments by one on each clock where `wdt_tick` is high. While the run bit is 0, or while the tick is low, the counter holds its value.
- R7: When the counter is FFh, the run bit is 1, the tick is high and no refresh is written, the counter becomes 00h. In that case `wdt_reset_req` is high for exactly the next cycle.
- R8: A wrap sets the expiry flag (control bit 7). The flag stays set until an unlocked control write with bit 7 = 1 clears it. A wrap in the same cycle as that write wins.
- R9: An unlocked control write with bit 1 = 1 clears the counter to zero, even when a tick arrives in the same cycle. The run bit takes the value in bit 0, and bit 1 always reads back as 0.
- R10: The key address reads the unlock state code (0, 1 or 2). Writes to the counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_tick | input | 1 | Watchdog tick enable; one count per high cycle while running |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| wdt_reset_req | output | 1 | One-cycle reset request after a wrap |

## Verification
Directed sequences run first:
- a correct unlock followed by one write;
- a broken sequence (1Eh, 55h, E1h), which must leave the block locked;
- a repeated write after the unlock is used up;
- a refresh that lands on a tick;
- a full 256-tick run to a wrap, which separates the one-cycle pulse from the sticky flag;
- ticks with the watchdog stopped.

These tell apart a guard that only checks the last key byte, an unlock that never expires, and a counter that ignores the run bit.

A seeded random phase then mixes key bytes weighted toward the two valid values, random control bytes and dense ticks. It reaches wraps, clears and refreshes in orders the directed part does not try.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned CNT_W_DEF  = 8;

    localparam logic [7:0] KEY_A_DEF = 8'h1E;
    localparam logic [7:0] KEY_B_DEF = 8'hE1;

    // control field positions (the bench and software decode these)
    localparam int unsigned BIT_RUN     = 0;
    localparam int unsigned BIT_REFRESH = 1;
    localparam int unsigned BIT_EXPIRED = 7;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_FIRST = 2'd1,
        LK_OPEN  = 2'd2
    } lock_e;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_KEY   = 2'd1,
        ADDR_COUNT = 2'd2,
        ADDR_NONE  = 2'd3
    } addr_e;

    typedef struct packed {
        logic       expired;
        logic [4:0] rsv;
        logic       refresh;
        logic       run;
    } ctrl_view_t;

    // next unlock state after a key-register write
    function automatic lock_e lock_step(lock_e cur, logic [7:0] val,
                                       logic [7:0] ka, logic [7:0] kb);
        lock_e nxt;
        case (cur)
            LK_FIRST: nxt = (val == kb) ? LK_OPEN : LK_IDLE;
            default:  nxt = (val == ka) ? LK_FIRST : LK_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock
    import kwdt_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter logic [7:0]  KEY_A  = KEY_A_DEF,
    parameter logic [7:0]  KEY_B  = KEY_B_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output lock_e             state_o,
    output logic              open_o
);

    lock_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_IDLE;
        end else if (key_wr) begin
            state_q <= lock_step(state_q, wdata[7:0], KEY_A, KEY_B);
        end else if (ctrl_wr && state_q == LK_OPEN) begin
            state_q <= LK_IDLE;
        end
    end

    assign state_o = state_q;
    assign open_o  = (state_q == LK_OPEN);

    // R5: one guarded write consumes the unlock
    assert_unlock_consumed_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !key_wr && state_q == LK_OPEN) |=> state_q == LK_IDLE);

    // R3: a wrong second byte drops back to idle
    assert_bad_second_key_R3: assert property (@(posedge clk) disable iff (rst)
        (key_wr && state_q == LK_FIRST && wdata[7:0] != KEY_B) |=> state_q == LK_IDLE);

    // R2: correct second byte opens
    assert_good_second_key_R2: assert property (@(posedge clk) disable iff (rst)
        (key_wr && state_q == LK_FIRST && wdata[7:0] == KEY_B) |=> state_q == LK_OPEN);

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic open_i,
    input  logic wr_run,
    input  logic wr_refresh,
    input  logic wr_clear,
    input  logic wrap_i,
    output logic run_o,
    output logic refresh_o,
    output logic expired_o
);

    logic accept;
    logic run_q;
    logic expired_q;

    assign accept    = ctrl_wr && open_i;
    assign refresh_o = accept && wr_refresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            expired_q <= 1'b0;
        end else begin
            if (accept) begin
                run_q <= wr_run;
            end
            if (wrap_i) begin
                expired_q <= 1'b1;
            end else if (accept && wr_clear) begin
                expired_q <= 1'b0;
            end
        end
    end

    assign run_o     = run_q;
    assign expired_o = expired_q;

    // R4: a locked control write changes nothing
    assert_locked_run_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !open_i) |=> $stable(run_q));

    // R8: flag stays set unless an accepted clear arrives
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (expired_q && !(accept && wr_clear)) |=> expired_q);

    // R8: a wrap always leaves the flag set
    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> expired_q);

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             step;

    assign step   = run_i && tick_i && !clear_i;
    assign wrap_o = step && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap_o;
            if (clear_i) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
    assign pulse_o = pulse_q;

    // R7: the reset request lasts one cycle
    assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R7: wrap gives a zero count and a request
    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !clear_i && cnt_q == CNT_MAX) |=> (pulse_q && cnt_q == '0));

    // R6: stopped or idle counter holds
    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        ((!run_i || !tick_i) && !clear_i) |=> $stable(cnt_q));

    // R6: running tick advances by one
    assert_step_by_one_R6: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !clear_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R9: refresh clears regardless of tick
    assert_refresh_clears_R9: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> cnt_q == '0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter logic [7:0]  KEY_A  = KEY_A_DEF,
    parameter logic [7:0]  KEY_B  = KEY_B_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wdt_tick,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdt_reset_req
);

    lock_e            lk_state;
    logic             lk_open;
    logic             key_wr;
    logic             ctrl_wr;
    logic             run;
    logic             refresh;
    logic             expired;
    logic             wrap;
    logic [CNT_W-1:0] count;
    ctrl_view_t       ctrl_view;

    assign key_wr  = reg_wr && (addr_e'(reg_addr) == ADDR_KEY);
    assign ctrl_wr = reg_wr && (addr_e'(reg_addr) == ADDR_CTRL);

    kwdt_unlock #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_unlock (
        .clk     (clk),
        .rst     (rst),
        .key_wr  (key_wr),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata),
        .state_o (lk_state),
        .open_o  (lk_open)
    );

    kwdt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .open_i     (lk_open),
        .wr_run     (reg_wdata[BIT_RUN]),
        .wr_refresh (reg_wdata[BIT_REFRESH]),
        .wr_clear   (reg_wdata[BIT_EXPIRED]),
        .wrap_i     (wrap),
        .run_o      (run),
        .refresh_o  (refresh),
        .expired_o  (expired)
    );

    kwdt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .tick_i  (wdt_tick),
        .clear_i (refresh),
        .count_o (count),
        .wrap_o  (wrap),
        .pulse_o (wdt_reset_req)
    );

    always_comb begin
        ctrl_view         = '0;
        ctrl_view.run     = run;
        ctrl_view.expired = expired;
    end

    always_comb begin
        case (addr_e'(reg_addr))
            ADDR_CTRL:  reg_rdata = DATA_W'(ctrl_view);
            ADDR_KEY:   reg_rdata = DATA_W'(lk_state);
            ADDR_COUNT: reg_rdata = DATA_W'(count);
            default:    reg_rdata = '0;
        endcase
    end

    // R1: no request while or right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !wdt_reset_req);

endmodule

// File: tb/kwdt_top_test.sv
`timescale 1ns/100ps
module kwdt_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wdt_tick = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       wdt_reset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    int         m_state = 0;
    bit         m_run = 0;
    bit         m_flag = 0;
    logic [7:0] m_cnt = 0;
    bit         m_req = 0;

    always #2.5 clk = ~clk;

    kwdt_top uut (
        .clk           (clk),
        .rst           (rst),
        .wdt_tick      (wdt_tick),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .wdt_reset_req (wdt_reset_req)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int key_next(int st, logic [7:0] v);
        if (st == 1) return (v == 8'hE1) ? 2 : 0;
        return (v == 8'h1E) ? 1 : 0;
    endfunction

    task automatic read_all(string ctx);
        reg_wr = 1'b0;
        wdt_tick = 1'b0;
        reg_addr = 2'd0; #0.3;
        check({ctx, " R4 R8 ctrl"}, reg_rdata, {m_flag, 6'b0, m_run});
        reg_addr = 2'd1; #0.3;
        check({ctx, " R10 key state"}, reg_rdata, 8'(m_state));
        reg_addr = 2'd2; #0.3;
        check({ctx, " R6 count"}, reg_rdata, m_cnt);
        reg_addr = 2'd3; #0.3;
        check({ctx, " R1 unused addr"}, reg_rdata, 8'h00);
    endtask

    // one clock with the given stimulus, model update and port checks
    task automatic step(bit wr, logic [1:0] a, logic [7:0] d, bit tk, string ctx);
        bit acc, refr, wrap;
        int st_n;
        reg_wr = wr; reg_addr = a; reg_wdata = d; wdt_tick = tk;
        acc  = wr && a == 2'd0 && m_state == 2;
        refr = acc && d[1];
        wrap = m_run && tk && !refr && m_cnt == 8'hFF;
        st_n = m_state;
        if (wr && a == 2'd1) st_n = key_next(m_state, d);
        else if (wr && a == 2'd0 && m_state == 2) st_n = 0;
        @(posedge clk);
        if (refr) m_cnt = 8'h00;
        else if (m_run && tk) m_cnt = m_cnt + 8'd1;
        if (wrap) m_flag = 1;
        else if (acc && d[7]) m_flag = 0;
        if (acc) m_run = d[0];
        m_state = st_n;
        m_req = wrap;
        @(negedge clk);
        #0.2;
        check({ctx, " R7 reset request"}, {7'b0, wdt_reset_req}, {7'b0, m_req});
        read_all(ctx);
    endtask

    task automatic unlock(string ctx);
        step(1, 2'd1, 8'h1E, 0, ctx);
        step(1, 2'd1, 8'hE1, 0, ctx);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog timeout");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.2;
        check("R1 request after reset", {7'b0, wdt_reset_req}, 8'h00);
        read_all("R1 reset");

        // R4: locked write ignored
        step(1, 2'd0, 8'h83, 0, "R4 locked write");
        step(0, 2'd0, 8'h00, 1, "R4 tick while stopped");

        // R2, R10: unlock path
        step(1, 2'd1, 8'h1E, 0, "R10 first byte");
        check("R10 state one", 8'(m_state), 8'd1);
        step(1, 2'd1, 8'hE1, 0, "R2 second byte");
        check("R2 open state", 8'(m_state), 8'd2);
        step(1, 2'd0, 8'h01, 0, "R2 enable write");
        check("R2 run set", {7'b0, m_run}, 8'd1);

        // R5: consumed unlock
        step(1, 2'd0, 8'h00, 0, "R5 second write ignored");
        check("R5 still running", {7'b0, m_run}, 8'd1);

        // R3: broken sequence
        step(1, 2'd1, 8'h1E, 0, "R3 seq a");
        step(1, 2'd1, 8'h55, 0, "R3 seq b");
        step(1, 2'd1, 8'hE1, 0, "R3 seq c");
        check("R3 not open", 8'(m_state), 8'd0);
        step(1, 2'd0, 8'h00, 0, "R3 write after broken seq");

        // R6: counting
        for (int i = 0; i < 5; i++) step(0, 2'd0, 8'h00, 1, "R6 tick");
        step(0, 2'd0, 8'h00, 0, "R6 no tick");
        check("R6 five ticks", m_cnt, 8'd5);
        step(1, 2'd2, 8'h77, 1, "R10 count write ignored");

        // R9: refresh on a tick
        unlock("R9 unlock");
        step(1, 2'd0, 8'h03, 1, "R9 refresh");
        check("R9 count zero", m_cnt, 8'd0);

        // R7, R8: full run to wrap
        for (int i = 0; i < 255; i++) step(0, 2'd0, 8'h00, 1, "R7 run up");
        check("R7 at max", m_cnt, 8'hFF);
        step(0, 2'd0, 8'h00, 1, "R7 wrap");
        check("R7 pulse expected", {7'b0, m_req}, 8'd1);
        step(0, 2'd0, 8'h00, 0, "R7 pulse gone");
        step(1, 2'd0, 8'h80, 0, "R8 locked clear ignored");
        check("R8 flag held", {7'b0, m_flag}, 8'd1);

        // R6: stop and hold
        unlock("R6 unlock");
        step(1, 2'd0, 8'h00, 0, "R6 stop");
        for (int i = 0; i < 4; i++) step(0, 2'd0, 8'h00, 1, "R6 stopped tick");

        // R8: accepted clear
        unlock("R8 unlock");
        step(1, 2'd0, 8'h81, 0, "R8 clear flag");
        check("R8 flag cleared", {7'b0, m_flag}, 8'd0);

        // random phase
        r = $urandom(32'h5EED);
        for (int i = 0; i < 6000; i++) begin
            r = $urandom % 100;
            if (r < 70) begin
                step(0, 2'($urandom % 4), 8'h00, ($urandom % 8) != 0, "rnd idle");
            end else if (r < 88) begin
                case ($urandom % 4)
                    0: v = 8'($urandom);
                    1: v = 8'hE1;
                    default: v = 8'h1E;
                endcase
                if (m_state == 1 && ($urandom % 3) != 0) v = 8'hE1;
                step(1, 2'd1, v, $urandom % 2, "rnd key");
            end else begin
                v = 8'($urandom);
                if (($urandom % 4) != 0) v[1] = 1'b0;
                if (($urandom % 3) != 0) v[0] = 1'b1;
                step(1, 2'($urandom % 3 == 0 ? 2 : 0), v, $urandom % 2, "rnd ctrl");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule